// File: doc/BRIEF.md
# Processor Status Register with Interrupt Gating

This block keeps the six live condition flags of an 8-bit processor core: negative, overflow, decimal, interrupt mask, zero and carry. Each cycle it can take per-flag results from the ALU, a single flag set/clear command, and one stack action. It forms the byte that goes onto the stack, and it loads the flags back from a byte read off the stack. Both bytes use a fixed bit layout, because the software sees it.

The block also decides whether an interrupt is accepted at each instruction boundary. The non-maskable request is edge-sensitive and is latched until it is serviced. The maskable request is a level, and it is gated by a copy of the mask flag that deliberately lags the architectural flag by one instruction. Return-from-interrupt is the exception and refreshes that copy at once. A registered vector output tells the fetch logic where the handler lives. The vector is the reset entry until the first interrupt or break.

Top module: `psr_irq_gate`

## Requirements
- R1: `status_o` and `push_o` both use the layout bit7 N, bit6 V, bit5 constant 1, bit4 B, bit3 D, bit2 I, bit1 Z, bit0 C. `status_o` always shows B as 0.
- R2: `push_o` carries B=1 when `stk_op_i` is 1 (software push) or 4 (break). It carries B=0 for 3 (hardware interrupt entry) and for every other code.
- R3: `stk_op_i` 2 (software pull) and 5 (return from interrupt) load N, V, D, I, Z, C from `pull_byte_i` bits 7, 6, 3, 2, 1, 0 on the next edge. Bits 5 and 4 of the pulled byte have no effect.
- R4: After CLI, SEI or a software pull, `status_o` shows the new I on the next edge. The IRQ poll at a boundary (`boundary_i`=1) still uses the I value that stood after the previous boundary. So one more instruction runs under the old mask.
- R5: On a return from interrupt (code 5), the pulled I gates the IRQ poll in the same cycle and in every cycle after it.
- R6: For codes 3 and 4, `push_o` shows the old I, and I reads 1 from the next edge. A break proceeds whatever I is and selects vector 0xFFFE.
- R7: A rising edge of `nmi_req_i` is latched. It is accepted at the next boundary whatever I is, and it takes precedence over IRQ. `vec_o` becomes 0xFFFA on the following edge. A request held high does not fire again.
- R8: If an NMI is pending during a break cycle, `vec_o` becomes 0xFFFA, the push byte keeps B=1, and the NMI is consumed, so no further take follows.
- R9: IRQ (`irq_req_i` high) is accepted at a boundary when the gating mask is 0 and no NMI is pending, and `vec_o` becomes 0xFFFE. `take_o` is 1 combinationally in the accepting boundary cycle.
- R10: `flag_op_i` codes: 1 clears C, 2 sets C, 3 clears D, 4 sets D, 5 clears I, 6 sets I, 7 clears V, 0 does nothing.
- R11: `alu_we_i`/`alu_val_i` bit3 N, bit2 V, bit1 Z, bit0 C update only the enabled flags. A pull overrides a flag command, and a flag command overrides the ALU. The ALU never changes D or I.
- R12: Reset leaves `status_o` at 0x24 (I=1, all other flags 0), `vec_o` at 0xFFFC and no NMI pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_val_i | input | 4 | ALU flag results N, V, Z, C |
| alu_we_i | input | 4 | Per-flag ALU update enables |
| flag_op_i | input | 3 | Flag set/clear command |
| stk_op_i | input | 3 | Stack action code |
| pull_byte_i | input | 8 | Status byte read from the stack |
| boundary_i | input | 1 | Instruction boundary (interrupt poll point) |
| irq_req_i | input | 1 | Maskable request, level |
| nmi_req_i | input | 1 | Non-maskable request, edge |
| status_o | output | 8 | Current flags in stack layout |
| push_o | output | 8 | Byte to write on a push or an entry |
| take_o | output | 1 | Interrupt accepted at this boundary |
| vec_o | output | 16 | Selected handler vector address |

## Verification
Two pairs of events can meet in one cycle, and the bench drives both on purpose. First, an I-changing command or pull can land on the same boundary where an IRQ is polled. The bench issues SEI, CLI, a software pull and a return each with `boundary_i` and `irq_req_i` high. It then checks that `take_o` follows the old mask for the first three and the new mask for the return. Second, a latched NMI can coincide with a break. The bench checks for vector 0xFFFA, B=1 in the push byte, and no take at the next boundary. Random mixes of both collisions are judged against a reference model held in the bench.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int ALU_N   = 4;
  localparam int BYTE_W  = 8;

  typedef enum logic [2:0] {
    FOP_NONE  = 3'd0,
    FOP_CLR_C = 3'd1,
    FOP_SET_C = 3'd2,
    FOP_CLR_D = 3'd3,
    FOP_SET_D = 3'd4,
    FOP_CLR_I = 3'd5,
    FOP_SET_I = 3'd6,
    FOP_CLR_V = 3'd7
  } flag_op_e;

  typedef enum logic [2:0] {
    STK_NONE     = 3'd0,
    STK_SW_PUSH  = 3'd1,
    STK_SW_PULL  = 3'd2,
    STK_HW_ENTRY = 3'd3,
    STK_BRK      = 3'd4,
    STK_RETURN   = 3'd5
  } stk_op_e;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;

  function automatic flags_t reset_flags();
    flags_t f;
    f   = '0;
    f.i = 1'b1;
    return f;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(flags_t f, logic brk_bit);
    return {f.n, f.v, 1'b1, brk_bit, f.d, f.i, f.z, f.c};
  endfunction

  function automatic flags_t unpack_status(logic [BYTE_W-1:0] b);
    flags_t f;
    f.n = b[7];
    f.v = b[6];
    f.d = b[3];
    f.i = b[2];
    f.z = b[1];
    f.c = b[0];
    return f;
  endfunction

endpackage

// File: rtl/psr_flag_bank.sv
module psr_flag_bank
  import psr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ALU_N-1:0]  alu_val,
  input  logic [ALU_N-1:0]  alu_we,
  input  flag_op_e          fop,
  input  stk_op_e           stk,
  input  logic [BYTE_W-1:0] pull_byte,
  input  logic              boundary,
  output flags_t            flags_q,
  output logic              poll_mask
);

  logic   pull_ld;
  logic   entry;
  logic   ret;
  flags_t pulled;
  flags_t nxt;
  logic   mask_q;
  logic   mask_d;

  assign pull_ld = (stk == STK_SW_PULL) || (stk == STK_RETURN);
  assign entry   = (stk == STK_HW_ENTRY) || (stk == STK_BRK);
  assign ret     = (stk == STK_RETURN);
  assign pulled  = unpack_status(pull_byte);

  // Precedence, lowest first: ALU, flag command, entry, pull.
  always_comb begin
    nxt = flags_q;
    if (alu_we[0]) nxt.c = alu_val[0];
    if (alu_we[1]) nxt.z = alu_val[1];
    if (alu_we[2]) nxt.v = alu_val[2];
    if (alu_we[3]) nxt.n = alu_val[3];
    unique case (fop)
      FOP_CLR_C: nxt.c = 1'b0;
      FOP_SET_C: nxt.c = 1'b1;
      FOP_CLR_D: nxt.d = 1'b0;
      FOP_SET_D: nxt.d = 1'b1;
      FOP_CLR_I: nxt.i = 1'b0;
      FOP_SET_I: nxt.i = 1'b1;
      FOP_CLR_V: nxt.v = 1'b0;
      default:   ;
    endcase
    if (entry)   nxt.i = 1'b1;
    if (pull_ld) nxt   = pulled;
  end

  // Gating copy of I: refreshed at boundaries, immediately by return/entry.
  assign poll_mask = ret ? pulled.i : mask_q;

  always_comb begin
    if (ret)           mask_d = pulled.i;
    else if (entry)    mask_d = 1'b1;
    else if (boundary) mask_d = nxt.i;
    else               mask_d = mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= reset_flags();
      mask_q  <= 1'b1;
    end else begin
      flags_q <= nxt;
      mask_q  <= mask_d;
    end
  end

endmodule

// File: rtl/psr_int_arb.sv
module psr_int_arb #(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [VEC_W-1:0] VEC_IRQ = 16'hFFFE,
  parameter logic [VEC_W-1:0] VEC_RST = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             irq_req,
  input  logic             nmi_req,
  input  logic             poll_mask,
  input  logic             brk_cycle,
  output logic             take_nmi,
  output logic             take_irq,
  output logic             nmi_pend,
  output logic [VEC_W-1:0] vec_q
);

  logic nmi_q;
  logic nmi_edge;
  logic hijack;

  function automatic logic [VEC_W-1:0] pick_vec(logic from_nmi);
    return from_nmi ? VEC_NMI : VEC_IRQ;
  endfunction

  assign nmi_edge = nmi_req & ~nmi_q;
  assign take_nmi = boundary & nmi_pend;
  assign take_irq = boundary & ~nmi_pend & irq_req & ~poll_mask;
  assign hijack   = brk_cycle & nmi_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
      vec_q    <= VEC_RST;
    end else begin
      nmi_q    <= nmi_req;
      nmi_pend <= nmi_edge | (nmi_pend & ~take_nmi & ~hijack);
      if (brk_cycle)
        vec_q <= pick_vec(nmi_pend);
      else if (take_nmi || take_irq)
        vec_q <= pick_vec(take_nmi);
    end
  end

endmodule

// File: rtl/psr_irq_gate.sv
module psr_irq_gate
  import psr_pkg::*;
#(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [VEC_W-1:0] VEC_IRQ = 16'hFFFE,
  parameter logic [VEC_W-1:0] VEC_RST = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       alu_val_i,
  input  logic [3:0]       alu_we_i,
  input  logic [2:0]       flag_op_i,
  input  logic [2:0]       stk_op_i,
  input  logic [7:0]       pull_byte_i,
  input  logic             boundary_i,
  input  logic             irq_req_i,
  input  logic             nmi_req_i,
  output logic [7:0]       status_o,
  output logic [7:0]       push_o,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o
);

  stk_op_e  stk;
  flag_op_e fop;
  flags_t   flags_q;
  logic     poll_mask;
  logic     take_nmi;
  logic     take_irq;
  logic     nmi_pend;
  logic     brk_cycle;
  logic     push_b;

  assign stk       = stk_op_e'(stk_op_i);
  assign fop       = flag_op_e'(flag_op_i);
  assign brk_cycle = (stk == STK_BRK);
  assign push_b    = (stk == STK_SW_PUSH) || brk_cycle;

  psr_flag_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .alu_val   (alu_val_i),
    .alu_we    (alu_we_i),
    .fop       (fop),
    .stk       (stk),
    .pull_byte (pull_byte_i),
    .boundary  (boundary_i),
    .flags_q   (flags_q),
    .poll_mask (poll_mask)
  );

  psr_int_arb #(
    .VEC_W   (VEC_W),
    .VEC_NMI (VEC_NMI),
    .VEC_IRQ (VEC_IRQ),
    .VEC_RST (VEC_RST)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (boundary_i),
    .irq_req   (irq_req_i),
    .nmi_req   (nmi_req_i),
    .poll_mask (poll_mask),
    .brk_cycle (brk_cycle),
    .take_nmi  (take_nmi),
    .take_irq  (take_irq),
    .nmi_pend  (nmi_pend),
    .vec_q     (vec_o)
  );

  assign status_o = pack_status(flags_q, 1'b0);
  assign push_o   = pack_status(flags_q, push_b);
  assign take_o   = take_nmi | take_irq;

endmodule

// File: rtl/psr_irq_gate_chk.sv
module psr_irq_gate_chk #(
  parameter int               VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_NMI = 16'hFFFA,
  parameter logic [VEC_W-1:0] VEC_IRQ = 16'hFFFE
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       stk_op_i,
  input logic [2:0]       flag_op_i,
  input logic             boundary_i,
  input logic             irq_req_i,
  input logic [7:0]       pull_byte_i,
  input logic [7:0]       status_o,
  input logic [7:0]       push_o,
  input logic             take_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             nmi_pend,
  input logic             take_nmi,
  input logic             take_irq,
  input logic             poll_mask
);

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    push_o[5] && status_o[5] && !status_o[4]); // R1

  AST_B_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_op_i == 3'd1 || stk_op_i == 3'd4) |-> push_o[4]); // R2

  AST_B_HW: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_op_i == 3'd3) |-> !push_o[4]); // R2

  AST_PULL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_op_i == 3'd2 || stk_op_i == 3'd5) |=>
      (status_o == {$past(pull_byte_i[7:6]), 2'b10, $past(pull_byte_i[3:0])})); // R3

  AST_MASK_CATCHUP: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_i |=> (stk_op_i == 3'd5 || poll_mask == status_o[2])); // R4

  AST_RETURN_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_op_i == 3'd5 && boundary_i && irq_req_i && !pull_byte_i[2]) |-> take_o); // R5

  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_op_i == 3'd3 || stk_op_i == 3'd4) |=> status_o[2]); // R6

  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> (vec_o == VEC_NMI)); // R7

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi, take_irq}) && (take_o == (take_nmi || take_irq))); // R7

  AST_BRK_HIJACK: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_op_i == 3'd4 && nmi_pend) |=> (vec_o == VEC_NMI)); // R8

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && stk_op_i != 3'd4) |=> (vec_o == VEC_IRQ)); // R9

  AST_CLEAR_V: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_op_i == 3'd7 && stk_op_i != 3'd2 && stk_op_i != 3'd5) |=> !status_o[6]); // R10

endmodule

bind psr_irq_gate psr_irq_gate_chk #(
  .VEC_W   (VEC_W),
  .VEC_NMI (VEC_NMI),
  .VEC_IRQ (VEC_IRQ)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stk_op_i    (stk_op_i),
  .flag_op_i   (flag_op_i),
  .boundary_i  (boundary_i),
  .irq_req_i   (irq_req_i),
  .pull_byte_i (pull_byte_i),
  .status_o    (status_o),
  .push_o      (push_o),
  .take_o      (take_o),
  .vec_o       (vec_o),
  .nmi_pend    (nmi_pend),
  .take_nmi    (take_nmi),
  .take_irq    (take_irq),
  .poll_mask   (poll_mask)
);

// File: tb/tb_psr_irq_gate.sv
`timescale 1ns/1ps
module tb_psr_irq_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  alu_v, alu_e;
  logic [2:0]  fop, stk;
  logic [7:0]  pb;
  logic        bnd, irq, nmi;
  logic [7:0]  status_o, push_o;
  logic        take_o;
  logic [15:0] vec_o;

  // reference model state, flags packed as {n,v,d,i,z,c}
  logic [5:0]  mf;
  logic        mmask, mpend, mnq;
  logic [15:0] mvec;
  logic        last_take;
  logic [7:0]  last_push;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  psr_irq_gate dut (
    .clk(clk), .rst_n(rst_n), .alu_val_i(alu_v), .alu_we_i(alu_e),
    .flag_op_i(fop), .stk_op_i(stk), .pull_byte_i(pb), .boundary_i(bnd),
    .irq_req_i(irq), .nmi_req_i(nmi), .status_o(status_o), .push_o(push_o),
    .take_o(take_o), .vec_o(vec_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_byte(logic [5:0] f, logic b);
    return {f[5], f[4], 1'b1, b, f[3], f[2], f[1], f[0]};
  endfunction

  task automatic idle();
    alu_v = '0; alu_e = '0; fop = '0; stk = '0; pb = '0; bnd = 1'b0; irq = 1'b0;
  endtask

  task automatic model_reset();
    mf = 6'b000100; mmask = 1'b1; mpend = 1'b0; mnq = 1'b0; mvec = 16'hFFFC;
  endtask

  task automatic step(input string tag);
    logic meff, etake, isret, ispull, isent;
    logic [5:0] nf;
    logic nmask, npend;
    logic [15:0] nvec;
    @(negedge clk);
    isret  = (stk == 3'd5);
    ispull = (stk == 3'd2) || isret;
    isent  = (stk == 3'd3) || (stk == 3'd4);
    meff   = isret ? pb[2] : mmask;
    etake  = bnd && (mpend || (irq && !meff));
    last_take = take_o;
    last_push = push_o;
    chk({tag, " status"}, {8'h0, status_o}, {8'h0, ref_byte(mf, 1'b0)});
    chk({tag, " push"}, {8'h0, push_o}, {8'h0, ref_byte(mf, (stk == 3'd1) || (stk == 3'd4))});
    chk({tag, " take"}, {15'h0, take_o}, {15'h0, etake});
    chk({tag, " vec"}, vec_o, mvec);
    // next flags, one flag at a time
    nf = mf;
    if (ispull)              nf[0] = pb[0];
    else if (fop == 3'd1)    nf[0] = 1'b0;
    else if (fop == 3'd2)    nf[0] = 1'b1;
    else if (alu_e[0])       nf[0] = alu_v[0];
    if (ispull)              nf[1] = pb[1];
    else if (alu_e[1])       nf[1] = alu_v[1];
    if (ispull)              nf[2] = pb[2];
    else if (isent)          nf[2] = 1'b1;
    else if (fop == 3'd5)    nf[2] = 1'b0;
    else if (fop == 3'd6)    nf[2] = 1'b1;
    if (ispull)              nf[3] = pb[3];
    else if (fop == 3'd3)    nf[3] = 1'b0;
    else if (fop == 3'd4)    nf[3] = 1'b1;
    if (ispull)              nf[4] = pb[6];
    else if (fop == 3'd7)    nf[4] = 1'b0;
    else if (alu_e[2])       nf[4] = alu_v[2];
    if (ispull)              nf[5] = pb[7];
    else if (alu_e[3])       nf[5] = alu_v[3];
    nmask = isret ? pb[2] : (isent ? 1'b1 : (bnd ? nf[2] : mmask));
    npend = (nmi && !mnq) || (mpend && !bnd && (stk != 3'd4));
    if (stk == 3'd4)               nvec = mpend ? 16'hFFFA : 16'hFFFE;
    else if (bnd && mpend)         nvec = 16'hFFFA;
    else if (bnd && irq && !meff)  nvec = 16'hFFFE;
    else                           nvec = mvec;
    @(posedge clk);
    #1;
    mf = nf; mmask = nmask; mpend = npend; mnq = nmi; mvec = nvec;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5021));
    idle();
    nmi = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R12 reset status", {8'h0, status_o}, 16'h0024);
    chk("R12 reset vector", vec_o, 16'hFFFC);
    rst_n = 1'b1;
    bnd = 1'b1; irq = 1'b1;
    step("R12 masked after reset");
    chk("R12 no take", {15'h0, last_take}, 16'h0);

    // R10 flag commands
    idle(); fop = 3'd2; step("R10 sec");  chk("R10 sec", {8'h0, status_o}, 16'h0025);
    fop = 3'd4; step("R10 sed");          chk("R10 sed", {8'h0, status_o}, 16'h002D);
    fop = 3'd5; step("R10 cli");          chk("R10 cli", {8'h0, status_o}, 16'h0029);
    fop = 3'd1; step("R10 clc");          chk("R10 clc", {8'h0, status_o}, 16'h0028);
    fop = 3'd6; step("R10 sei");          chk("R10 sei", {8'h0, status_o}, 16'h002C);
    fop = 3'd3; step("R10 cld");          chk("R10 cld", {8'h0, status_o}, 16'h0024);
    idle(); alu_e = 4'b0100; alu_v = 4'b0100; step("R11 set v");
    chk("R11 alu v", {8'h0, status_o}, 16'h0064);
    idle(); fop = 3'd7; step("R10 clv");  chk("R10 clv", {8'h0, status_o}, 16'h0024);

    // R11 precedence
    idle(); alu_e = 4'hF; alu_v = 4'b1011; step("R11 alu all");
    chk("R11 alu nzc", {8'h0, status_o}, 16'h00A7);
    idle(); fop = 3'd1; alu_e = 4'b0001; alu_v = 4'b0001; step("R11 cmd over alu");
    chk("R11 cmd over alu", {8'h0, status_o}, 16'h00A6);
    idle(); stk = 3'd2; pb = 8'h41; fop = 3'd2; alu_e = 4'hF; alu_v = 4'hF; step("R11 pull wins");
    chk("R11 pull wins", {8'h0, status_o}, 16'h0061);

    // R3 pull layout
    idle(); stk = 3'd2; pb = 8'hCB; step("R3 pull");
    chk("R3 pull cb", {8'h0, status_o}, 16'h00EB);
    idle(); stk = 3'd5; pb = 8'h34; step("R3 return");
    chk("R3 return 34", {8'h0, status_o}, 16'h0024);

    // R4 delayed mask
    idle(); stk = 3'd5; pb = 8'h00; step("R4 prep");
    idle(); fop = 3'd6; bnd = 1'b1; irq = 1'b1; step("R4 sei");
    chk("R4 sei old mask", {15'h0, last_take}, 16'h1);
    idle(); bnd = 1'b1; irq = 1'b1; step("R4 after sei");
    chk("R4 after sei", {15'h0, last_take}, 16'h0);
    idle(); fop = 3'd5; bnd = 1'b1; irq = 1'b1; step("R4 cli");
    chk("R4 cli old mask", {15'h0, last_take}, 16'h0);
    idle(); bnd = 1'b1; irq = 1'b1; step("R4 after cli");
    chk("R4 after cli", {15'h0, last_take}, 16'h1);
    idle(); fop = 3'd6; bnd = 1'b1; step("R4 sei again");
    idle(); stk = 3'd2; pb = 8'h00; bnd = 1'b1; irq = 1'b1; step("R4 pull");
    chk("R4 pull old mask", {15'h0, last_take}, 16'h0);
    idle(); bnd = 1'b1; irq = 1'b1; step("R4 after pull");
    chk("R4 after pull", {15'h0, last_take}, 16'h1);

    // R5 return applies at once
    idle(); fop = 3'd6; bnd = 1'b1; step("R5 prep");
    idle(); stk = 3'd5; pb = 8'h00; bnd = 1'b1; irq = 1'b1; step("R5 return");
    chk("R5 immediate", {15'h0, last_take}, 16'h1);

    // R7 NMI
    idle(); fop = 3'd6; bnd = 1'b1; step("R7 prep");
    idle(); nmi = 1'b1; step("R7 edge");
    idle(); bnd = 1'b1; step("R7 take");
    chk("R7 take masked", {15'h0, last_take}, 16'h1);
    chk("R7 vector", vec_o, 16'hFFFA);
    idle(); bnd = 1'b1; step("R7 held");
    chk("R7 no retrigger", {15'h0, last_take}, 16'h0);
    nmi = 1'b0; idle(); step("R7 release");

    // R6 entries
    idle(); stk = 3'd4; step("R6 brk");
    chk("R6 brk push", {8'h0, last_push}, 16'h0034);
    chk("R6 brk vector", vec_o, 16'hFFFE);
    idle(); fop = 3'd5; step("R6 prep");
    idle(); stk = 3'd3; step("R6 hw entry");
    chk("R6 hw push", {8'h0, last_push}, 16'h0020);
    chk("R6 i set", {8'h0, status_o}, 16'h0024);

    // R8 NMI over BRK
    idle(); nmi = 1'b1; step("R8 edge");
    idle(); stk = 3'd4; step("R8 brk");
    chk("R8 push b", {8'h0, last_push}, 16'h0034);
    chk("R8 vector", vec_o, 16'hFFFA);
    idle(); bnd = 1'b1; step("R8 consumed");
    chk("R8 consumed", {15'h0, last_take}, 16'h0);
    nmi = 1'b0; idle(); step("R8 release");

    // R9 IRQ
    idle(); stk = 3'd5; pb = 8'h00; step("R9 prep");
    idle(); bnd = 1'b1; irq = 1'b1; step("R9 take");
    chk("R9 take", {15'h0, last_take}, 16'h1);
    chk("R9 vector", vec_o, 16'hFFFE);
    idle(); bnd = 1'b1; step("R9 level low");
    chk("R9 low", {15'h0, last_take}, 16'h0);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int r;
      alu_v = 4'($urandom);
      alu_e = 4'($urandom);
      fop   = ($urandom % 2) ? 3'($urandom) : 3'd0;
      r     = $urandom % 16;
      stk   = (r == 10) ? 3'd1 : (r == 11) ? 3'd2 : (r == 12) ? 3'd3 :
              (r == 13) ? 3'd4 : (r == 14) ? 3'd5 : 3'd0;
      pb    = 8'($urandom);
      bnd   = ($urandom % 3) == 0;
      irq   = 1'($urandom);
      if (($urandom % 16) == 0) nmi = ~nmi;
      step("R1/R2/R7/R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule